// File: doc/BRIEF.md
# Predicated Nested Element Loop Sequencer

This block turns one vectorised scalar instruction into an ordered series of element steps. An outer loop walks the element offset from the resume point up to VL-1. For every element, an inner loop walks the sub-element offset up to SUBVL-1. Each cycle the block presents one step: its element and sub-element offsets, whether the step is issued, whether the result may be written, and whether the value to write is zero.

A predicate mask supplies one bit per element, and that bit governs every sub-element of the element. The mask may be read in complemented form, and masked positions are either zero-filled or left untouched. A fail-on-first mode ends the run at the first enabled element that reports a failure. The truncated element count is then handed back as the new vector length. Offsets are loaded from resume inputs at start, so an instruction that was interrupted can continue at the element where it stopped. The block does not read or write registers, perform the operation, or deliver traps.

Top module: `elem_loop_seq`

## Requirements
- R1: After `start`, steps are presented one per cycle from the cycle after the start edge. The first step is at (`resume_elem`, `resume_sub`); `resume_sub` reads as 0 when it exceeds `subvl_m1`. The element offset is the outer loop and the sub-element offset the inner loop. The group size is `subvl_m1`+1.
- R2: The enable bit of an element is `pred_mask[elem_off]` XOR `pred_inv` when `pred_use` is 1, and is always 1 when `pred_use` is 0. That one bit applies to every sub-element of the element.
- R3: An enabled step has `step_valid`=1, `step_we`=1, `step_zero`=0. With `pred_zero`=1, a disabled step has `step_valid`=1, `step_we`=1, `step_zero`=1. With `pred_zero`=0, a disabled element takes one cycle with `step_valid`=0 and `step_we`=0, and its sub-elements are skipped.
- R4: In fail-on-first mode, an enabled step whose selected fail input is high has `step_we`=0. The run ends there, and `trunc`=1 with `new_vl` equal to that element offset.
- R5: `ff_mode` encodes 2'b01 as fault mode (only `elem_fault` is honoured) and 2'b10 as condition mode (only `elem_cond_fail` is honoured). 2'b00 and 2'b11 both disable fail-on-first.
- R6: `done` is high for exactly one cycle, in the cycle after the final step, with `busy`=0. After a complete run, `trunc`=0 and `new_vl` equals the VL given at start.
- R7: While busy, the pair (element offset, sub-element offset) strictly increases from each cycle to the next.
- R8: With VL=1, `subvl_m1`=0 and `pred_use`=0, exactly one written step at offsets (0,0) is produced, followed by `done`.
- R9: If `resume_elem` is not below VL at start, no step is issued, `done` rises in the next cycle and `new_vl` equals VL.
- R10: `start` while busy is ignored, and so are any changes to the configuration inputs during a run.
- R11: After reset, `busy`, `done`, `trunc`, `step_valid`, `step_we` and `step_zero` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run; ignored while busy |
| vl | input | VL_W | Element count, 1..MAX_VL |
| subvl_m1 | input | 2 | Group size minus one |
| pred_use | input | 1 | Apply the predicate mask |
| pred_mask | input | MAX_VL | One enable bit per element |
| pred_inv | input | 1 | Use the mask complemented |
| pred_zero | input | 1 | Zero-fill masked positions |
| ff_mode | input | 2 | Fail-on-first mode select |
| elem_fault | input | 1 | Fault report for the current step |
| elem_cond_fail | input | 1 | Condition-fail report for the current step |
| resume_elem | input | OFF_W | Element offset to start from |
| resume_sub | input | 2 | Sub-element offset to start from |
| busy | output | 1 | A run is in progress |
| step_valid | output | 1 | The current step is issued |
| step_we | output | 1 | The current step may be written |
| step_zero | output | 1 | The value to write is zero |
| elem_off | output | OFF_W | Current element offset |
| sub_off | output | 2 | Current sub-element offset |
| done | output | 1 | One-cycle end-of-run pulse |
| trunc | output | 1 | The run was cut short by a failure |
| new_vl | output | VL_W | Resulting element count |

## Verification
A corrupted offset counter shows on `elem_off` or `sub_off` in the very next step. It also breaks the strictly ascending order, and it can shift the `done` pulse by one or more cycles. A wrong latched predicate bit or mode shows in the same cycle as a mismatch on `step_valid`, `step_we` or `step_zero`. The bench therefore compares every step of every run against a step-by-step model, and then compares `new_vl` and `trunc` at the `done` cycle.

// File: rtl/elem_loop_pkg.sv
// Shared types for the element loop sequencer.
// Assumes: the fail-on-first mode is a two-bit code held for a whole run.
package elem_loop_pkg;
    typedef enum logic [1:0] {
        FFM_OFF   = 2'b00,
        FFM_FAULT = 2'b01,
        FFM_COND  = 2'b10,
        FFM_RSVD  = 2'b11
    } ff_mode_e;
endpackage

// File: rtl/pred_select.sv
// Picks the enable bit of one element from a latched predicate mask.
// Assumes: idx is always below MAX_VL.
module pred_select #(
    parameter int MAX_VL = 16,
    localparam int OFF_W = $clog2(MAX_VL)
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic              use_mask,
    input  logic              invert,
    input  logic [OFF_W-1:0]  idx,
    output logic              grp_en
);
    // Mask bit, optionally complemented; all enabled when unused.
    always_comb begin
        grp_en = use_mask ? (mask[idx] ^ invert) : 1'b1;
    end
endmodule

// File: rtl/fail_judge.sv
// Decides whether the current step ends the run under fail-on-first.
// Assumes: fail inputs refer to the step currently presented.
module fail_judge
    import elem_loop_pkg::*;
(
    input  ff_mode_e mode,
    input  logic     active,
    input  logic     grp_en,
    input  logic     fault,
    input  logic     cond_fail,
    output logic     fail_hit
);
    // Honour only the indication that matches the selected mode.
    always_comb begin
        unique case (mode)
            FFM_FAULT: fail_hit = active & grp_en & fault;
            FFM_COND:  fail_hit = active & grp_en & cond_fail;
            default:   fail_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/loop_ctr.sv
// Nested element / sub-element counters with run control and completion.
// Assumes: load is asserted only while not busy.
module loop_ctr #(
    parameter int MAX_VL = 16,
    localparam int OFF_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_elem,
    input  logic [1:0]       load_sub,
    input  logic             load_empty,
    input  logic [VL_W-1:0]  load_vl,
    input  logic [VL_W-1:0]  cfg_vl,
    input  logic [1:0]       cfg_sub_m1,
    input  logic             grp_en,
    input  logic             zero_en,
    input  logic             fail_hit,
    output logic             busy,
    output logic [OFF_W-1:0] elem,
    output logic [1:0]       sub,
    output logic             done,
    output logic             trunc,
    output logic [VL_W-1:0]  new_vl
);
    logic group_end;
    logic last_elem;

    // End of group: last sub-element, or a masked group that is skipped whole.
    always_comb begin
        group_end = (sub == cfg_sub_m1) | (~grp_en & ~zero_en);
        last_elem = (VL_W'(elem) + VL_W'(1)) == cfg_vl;
    end

    // Advance offsets, finish on last step or on a fail-on-first hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            elem   <= '0;
            sub    <= '0;
            done   <= 1'b0;
            trunc  <= 1'b0;
            new_vl <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                elem  <= load_elem;
                sub   <= load_sub;
                trunc <= 1'b0;
                if (load_empty) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    new_vl <= load_vl;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (fail_hit) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    trunc  <= 1'b1;
                    new_vl <= VL_W'(elem);
                end else if (group_end) begin
                    if (last_elem) begin
                        busy   <= 1'b0;
                        done   <= 1'b1;
                        new_vl <= cfg_vl;
                    end else begin
                        elem <= elem + OFF_W'(1);
                        sub  <= '0;
                    end
                end else begin
                    sub <= sub + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/elem_loop_seq.sv
// Top of the predicated nested element loop sequencer.
// Latches the run configuration at start, then presents one step per cycle.
// Assumes: 1 <= vl <= MAX_VL; fail inputs are valid in the step's own cycle.
module elem_loop_seq
    import elem_loop_pkg::*;
#(
    parameter int MAX_VL = 16,
    localparam int OFF_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic [1:0]        subvl_m1,
    input  logic              pred_use,
    input  logic [MAX_VL-1:0] pred_mask,
    input  logic              pred_inv,
    input  logic              pred_zero,
    input  logic [1:0]        ff_mode,
    input  logic              elem_fault,
    input  logic              elem_cond_fail,
    input  logic [OFF_W-1:0]  resume_elem,
    input  logic [1:0]        resume_sub,
    output logic              busy,
    output logic              step_valid,
    output logic              step_we,
    output logic              step_zero,
    output logic [OFF_W-1:0]  elem_off,
    output logic [1:0]        sub_off,
    output logic              done,
    output logic              trunc,
    output logic [VL_W-1:0]   new_vl
);
    logic [VL_W-1:0]   cfg_vl;
    logic [1:0]        cfg_sub_m1;
    logic              cfg_use;
    logic [MAX_VL-1:0] cfg_mask;
    logic              cfg_inv;
    logic              cfg_zero;
    ff_mode_e          cfg_mode;
    logic              load;
    logic              load_empty;
    logic [1:0]        load_sub;
    logic              grp_en;
    logic              fail_hit;

    // Start is accepted only when idle; decide empty runs and resume clamp.
    always_comb begin
        load       = start & ~busy;
        load_empty = VL_W'(resume_elem) >= vl;
        load_sub   = (resume_sub > subvl_m1) ? 2'd0 : resume_sub;
    end

    // Capture the run configuration on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_vl     <= VL_W'(1);
            cfg_sub_m1 <= '0;
            cfg_use    <= 1'b0;
            cfg_mask   <= '0;
            cfg_inv    <= 1'b0;
            cfg_zero   <= 1'b0;
            cfg_mode   <= FFM_OFF;
        end else if (load) begin
            cfg_vl     <= vl;
            cfg_sub_m1 <= subvl_m1;
            cfg_use    <= pred_use;
            cfg_mask   <= pred_mask;
            cfg_inv    <= pred_inv;
            cfg_zero   <= pred_zero;
            cfg_mode   <= ff_mode_e'(ff_mode);
        end
    end

    pred_select #(.MAX_VL(MAX_VL)) u_pred (
        .mask     (cfg_mask),
        .use_mask (cfg_use),
        .invert   (cfg_inv),
        .idx      (elem_off),
        .grp_en   (grp_en)
    );

    fail_judge u_fail (
        .mode      (cfg_mode),
        .active    (busy),
        .grp_en    (grp_en),
        .fault     (elem_fault),
        .cond_fail (elem_cond_fail),
        .fail_hit  (fail_hit)
    );

    loop_ctr #(.MAX_VL(MAX_VL)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_elem  (resume_elem),
        .load_sub   (load_sub),
        .load_empty (load_empty),
        .load_vl    (vl),
        .cfg_vl     (cfg_vl),
        .cfg_sub_m1 (cfg_sub_m1),
        .grp_en     (grp_en),
        .zero_en    (cfg_zero),
        .fail_hit   (fail_hit),
        .busy       (busy),
        .elem       (elem_off),
        .sub        (sub_off),
        .done       (done),
        .trunc      (trunc),
        .new_vl     (new_vl)
    );

    // Step flags: issue, write permission and zero-fill for the current step.
    always_comb begin
        step_valid = busy & (grp_en | cfg_zero);
        step_we    = busy & ((grp_en & ~fail_hit) | (~grp_en & cfg_zero));
        step_zero  = busy & ~grp_en & cfg_zero;
    end
endmodule

// File: rtl/elem_loop_seq_chk.sv
// Property checker for elem_loop_seq, attached by bind.
module elem_loop_seq_chk #(
    parameter int MAX_VL = 16,
    localparam int OFF_W = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             step_valid,
    input logic             step_we,
    input logic             step_zero,
    input logic [OFF_W-1:0] elem_off,
    input logic [1:0]       sub_off,
    input logic             done,
    input logic             trunc,
    input logic [VL_W-1:0]  new_vl,
    input logic [VL_W-1:0]  cfg_vl,
    input logic [1:0]       cfg_sub_m1
);
    AST_STEP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid | step_we) |-> busy); // R1
    AST_SUB_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sub_off <= cfg_sub_m1)); // R1
    AST_ZERO_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        step_zero |-> (step_we & step_valid)); // R3
    AST_TRUNC_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
        (done & trunc) |-> (new_vl < cfg_vl)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & $past(busy)) |-> ({elem_off, sub_off} > $past({elem_off, sub_off}))); // R7
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .step_valid (step_valid),
    .step_we    (step_we),
    .step_zero  (step_zero),
    .elem_off   (elem_off),
    .sub_off    (sub_off),
    .done       (done),
    .trunc      (trunc),
    .new_vl     (new_vl),
    .cfg_vl     (cfg_vl),
    .cfg_sub_m1 (cfg_sub_m1)
);

// File: tb/test_elem_loop_seq.sv
// Self-checking bench: directed corners plus seeded random runs, each step
// compared with a bench model of the loop rules.
module test_elem_loop_seq;
    localparam int MAX_VL = 16;
    localparam int OFF_W  = $clog2(MAX_VL);
    localparam int VL_W   = $clog2(MAX_VL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VL_W-1:0]   vl = VL_W'(1);
    logic [1:0]        subvl_m1 = '0;
    logic              pred_use = 1'b0;
    logic [MAX_VL-1:0] pred_mask = '0;
    logic              pred_inv = 1'b0;
    logic              pred_zero = 1'b0;
    logic [1:0]        ff_mode = '0;
    logic              elem_fault;
    logic              elem_cond_fail;
    logic [OFF_W-1:0]  resume_elem = '0;
    logic [1:0]        resume_sub = '0;
    logic              busy, step_valid, step_we, step_zero, done, trunc;
    logic [OFF_W-1:0]  elem_off;
    logic [1:0]        sub_off;
    logic [VL_W-1:0]   new_vl;

    logic fault_arm = 1'b0;
    logic cond_arm  = 1'b0;
    int   fail_at   = 0;
    int   checks    = 0;
    int   errors    = 0;
    int   last_steps = 0;
    bit   finished  = 0;

    always #2.5 clk = ~clk;

    assign elem_fault     = fault_arm & busy & (int'(elem_off) == fail_at);
    assign elem_cond_fail = cond_arm  & busy & (int'(elem_off) == fail_at);

    elem_loop_seq #(.MAX_VL(MAX_VL)) i_elem_loop_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl_m1(subvl_m1),
        .pred_use(pred_use), .pred_mask(pred_mask), .pred_inv(pred_inv),
        .pred_zero(pred_zero), .ff_mode(ff_mode), .elem_fault(elem_fault),
        .elem_cond_fail(elem_cond_fail), .resume_elem(resume_elem),
        .resume_sub(resume_sub), .busy(busy), .step_valid(step_valid),
        .step_we(step_we), .step_zero(step_zero), .elem_off(elem_off),
        .sub_off(sub_off), .done(done), .trunc(trunc), .new_vl(new_vl)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Model of the enable bit (R2).
    function automatic int pbit(int use_p, int mask, int inv, int e);
        if (use_p == 0) return 1;
        return ((mask >> e) & 1) ^ inv;
    endfunction

    // One run: start at a negedge, then compare every step and the completion.
    task automatic run_case(int v, int sm1, int use_p, int mask, int inv, int zero,
                            int mode, int farm, int carm, int fat, int re, int rs,
                            int glitch);
        int e, s, pb, fl, exp_nvl, exp_tr, k;
        bit stop;
        vl = VL_W'(v); subvl_m1 = 2'(sm1); pred_use = 1'(use_p);
        pred_mask = MAX_VL'(mask); pred_inv = 1'(inv); pred_zero = 1'(zero);
        ff_mode = 2'(mode); resume_elem = OFF_W'(re); resume_sub = 2'(rs);
        fault_arm = 1'(farm); cond_arm = 1'(carm); fail_at = fat;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e = re; s = (rs > sm1) ? 0 : rs; stop = (re >= v);
        exp_nvl = v; exp_tr = 0; k = 0; last_steps = 0;
        while (!stop) begin
            if (glitch != 0 && k == 1) begin
                start = 1'b1; vl = VL_W'(1); pred_use = ~pred_use; // R10
            end else begin
                start = 1'b0;
            end
            pb = pbit(use_p, mask, inv, e);
            fl = (pb == 1 && e == fat &&
                  ((mode == 1 && farm != 0) || (mode == 2 && carm != 0))) ? 1 : 0;
            check("R1", "busy", int'(busy), 1);
            check("R1", "elem_off", int'(elem_off), e);
            check("R7", "sub_off", int'(sub_off), s);
            check("R2", "step_valid", int'(step_valid), (pb == 1 || zero != 0) ? 1 : 0);
            check(fl != 0 ? "R4" : "R3", "step_we", int'(step_we),
                  ((pb == 1 && fl == 0) || (pb == 0 && zero != 0)) ? 1 : 0);
            check("R3", "step_zero", int'(step_zero), (pb == 0 && zero != 0) ? 1 : 0);
            if (step_we) last_steps++;
            if (fl != 0) begin
                stop = 1; exp_tr = 1; exp_nvl = e;
            end else if ((pb == 0 && zero == 0) || s == sm1) begin
                if (e == v - 1) stop = 1;
                else begin e++; s = 0; end
            end else s++;
            k++;
            @(negedge clk);
        end
        start = 1'b0;
        check(re >= v ? "R9" : "R6", "done", int'(done), 1);
        check("R6", "busy at done", int'(busy), 0);
        check(exp_tr != 0 ? "R4" : "R6", "new_vl", int'(new_vl), exp_nvl);
        check("R4", "trunc", int'(trunc), exp_tr);
        @(negedge clk);
        check("R6", "done after pulse", int'(done), 0);
        fault_arm = 1'b0; cond_arm = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init, v, sm1, rs;
        seed_init = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check("R11", "busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "busy", int'(busy), 0);
        check("R11", "done", int'(done), 0);
        check("R11", "trunc", int'(trunc), 0);
        check("R11", "step flags", int'({step_valid, step_we, step_zero}), 0);

        // R8: scalar-equivalent run.
        run_case(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R8", "written steps", last_steps, 1);
        // R2 R3: grouped predicate, skip and zero-fill, plain and inverted.
        run_case(4, 2, 1, 'b0101, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3", "written steps skip", last_steps, 6);
        run_case(4, 2, 1, 'b0101, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R3", "written steps zero", last_steps, 12);
        // R4: fault stops at element 2.
        run_case(6, 1, 0, 0, 0, 0, 1, 1, 0, 2, 0, 0, 0);
        check("R4", "written before fail", last_steps, 4);
        // R5: mismatched indications ignored, reserved code disables.
        run_case(5, 0, 0, 0, 0, 0, 2, 1, 0, 1, 0, 0, 0);
        check("R5", "cond mode ignores fault", int'(trunc), 0);
        run_case(5, 0, 0, 0, 0, 0, 3, 1, 1, 1, 0, 0, 0);
        check("R5", "reserved mode", int'(trunc), 0);
        run_case(5, 1, 0, 0, 0, 0, 2, 0, 1, 3, 0, 0, 0);
        check("R5", "cond mode honoured", int'(trunc), 1);
        // R4: failing element masked off is not a failure.
        run_case(5, 0, 1, 'b11011, 0, 0, 1, 1, 0, 2, 0, 0, 0);
        // R1: resume mid-group.
        run_case(5, 3, 0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0);
        check("R1", "resumed steps", last_steps, 7);
        // R9: resume beyond VL.
        run_case(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7, 0, 0);
        check("R9", "no steps", last_steps, 0);
        // R10: start during a run.
        run_case(6, 1, 1, 'h2d, 0, 1, 0, 0, 0, 0, 0, 0, 1);
        check("R10", "steps unchanged", last_steps, 12);

        for (int n = 0; n < 80; n++) begin
            v   = 1 + int'($urandom % MAX_VL);
            sm1 = int'($urandom % 4);
            rs  = ($urandom % 4 == 0) ? int'($urandom % (sm1 + 1)) : 0;
            run_case(v, sm1, int'($urandom % 2), int'($urandom % 65536),
                     int'($urandom % 2), int'($urandom % 2), int'($urandom % 4),
                     int'($urandom % 2), int'($urandom % 2), int'($urandom % MAX_VL),
                     ($urandom % 4 == 0) ? int'($urandom % MAX_VL) : 0, rs, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule